// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block runs the stack-related and vectored control transfers of a small 8-bit processor core. The core hands it one command code together with the current program counter, a jump target, the current status byte and the accumulator. The block then walks a short fixed sequence of byte accesses on a 16-bit-address memory port. It owns the 8-bit stack pointer and returns the new program counter, the new status byte, the accumulator value and the number of processor cycles the operation accounts for.

The stack sits in memory page 1. A push stores at 0x0100 plus the pointer and then moves the pointer down. A pull moves the pointer up first and then reads. Return addresses are adjusted by one in either direction depending on the operation. The status byte has its bit 4 and bit 5 forced on some stack transfers. The three vectored events each read their new program counter, low byte first, from their own fixed pair of top-of-memory locations.

Each operation keeps the block busy for exactly its cycle cost. There is at most one memory access per cycle. A one-cycle done pulse marks the last cycle, and in that cycle all results are already final.

Top module: `stk_irq_seq`

## Requirements
- R1: After the synchronous reset input `rst`, `busy`, `done`, `mem_rd` and `mem_wr` are 0, `sp_out` is 0xFF, and `pc_out`, `status_out`, `acc_out` and `cycles_out` are 0.
- R2: A push writes to address 0x0100+SP and then decrements SP modulo 256. A push at SP=0x00 writes 0x0100 and leaves SP at 0xFF.
- R3: A pull first increments SP modulo 256 and then reads 0x0100+SP. A pull at SP=0xFF reads 0x0100 and leaves SP at 0x00.
- R4: A 16-bit value is pushed high byte first, then low byte. It is pulled low byte first, then high byte. Vectors are read from their low address (low byte) first, then from the address one higher.
- R5: Command code 0 (reset) sets SP to 0xFF, status to 0x00 and the accumulator to 0x00. It loads the PC from 0xFFFC/0xFFFD and costs 7 cycles.
- R6: Command code 1 (NMI) pushes the PC and then the unmodified status byte. The new status is the old status with bit 2 set. The PC is loaded from 0xFFFA/0xFFFB and the cost is 7 cycles.
- R7: Command code 2 (break) pushes PC+1 and then the status with bits 4 and 5 set. It loads the PC from 0xFFFE/0xFFFF, leaves the status output unchanged, and costs 7 cycles.
- R8: Command code 3 (return from interrupt) pulls a status byte and stores it with bit 5 set. It then pulls the PC. The cost is 6 cycles.
- R9: Command code 4 (call) pushes PC-1 modulo 65536 and sets the PC output to the target input, at a cost of 6 cycles. Command code 5 (return) pulls a word and outputs it plus 1 modulo 65536, at a cost of 6 cycles.
- R10: Command code 6 pushes the accumulator input at a cost of 3 cycles. Command code 7 pulls a byte into the accumulator output at a cost of 4 cycles.
- R11: Command code 8 pushes the status input with bits 4 and 5 set, at a cost of 3 cycles. Command code 9 pulls a byte, clears its bit 4, sets its bit 5, stores it as the status, and costs 4 cycles.
- R12: An accepted command keeps `busy` high for exactly `cycles_out` cycles. `done` is high only in the last of these cycles, with all outputs final. No cycle has both a read and a write.
- R13: A command presented while busy, or with a code of 10 to 15, is ignored: no access is made and SP is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| pc_in | input | 16 | Current program counter |
| tgt_in | input | 16 | Call target address |
| status_in | input | 8 | Current status byte |
| acc_in | input | 8 | Accumulator value to push |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data sampled at the clock edge |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles_out | output | 4 | Cycle cost of the last accepted operation |
| pc_out | output | 16 | New program counter |
| status_out | output | 8 | New status byte |
| acc_out | output | 8 | Accumulator after reset or pull |
| sp_out | output | 8 | Stack pointer |

## Verification
All ten commands are issued, and every cycle's strobes, address, write data and stack pointer are compared against an independent reference. Status values are chosen with bits 4 and 5 both clear and both set, which separates forcing on push from forcing on pull. A call from address 0x0000 followed by a return exposes the ±1 adjustments and their 16-bit wrap. A run of 256 accumulator pushes followed by a pull drives the pointer through both wrap points. A second command held during an NMI and an undefined code show that foreign commands are dropped.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

    localparam int unsigned AW     = 16;
    localparam int unsigned DW     = 8;
    localparam int unsigned CYC_W  = 4;
    localparam int unsigned NUM_OP = 10;

    localparam logic [AW-1:0] STACK_PAGE = 16'h0100;
    localparam logic [AW-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST    = 16'hFFFC;
    localparam logic [AW-1:0] VEC_BRK    = 16'hFFFE;

    localparam logic [DW-1:0] ST_BRKBIT  = 8'h10;
    localparam logic [DW-1:0] ST_ONEBIT  = 8'h20;
    localparam logic [DW-1:0] ST_MASKBIT = 8'h04;

    typedef enum logic [3:0] {
        CMD_RESET = 4'd0,
        CMD_NMI   = 4'd1,
        CMD_BRK   = 4'd2,
        CMD_RTI   = 4'd3,
        CMD_CALL  = 4'd4,
        CMD_RET   = 4'd5,
        CMD_PSHA  = 4'd6,
        CMD_PULA  = 4'd7,
        CMD_PSHS  = 4'd8,
        CMD_PULS  = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {U_IDLE, U_PUSH, U_PULL, U_VEC} ukind_e;
    typedef enum logic [1:0] {B_LO, B_HI, B_ST, B_AC} usel_e;

    typedef struct packed {
        ukind_e kind;
        usel_e  sel;
    } uop_t;

    function automatic logic cmd_ok(input logic [3:0] c);
        return int'(c) < NUM_OP;
    endfunction

    function automatic logic [CYC_W-1:0] op_cost(input cmd_e op);
        unique case (op)
            CMD_RESET, CMD_NMI, CMD_BRK: return 4'd7;
            CMD_RTI, CMD_CALL, CMD_RET:  return 4'd6;
            CMD_PSHA, CMD_PSHS:          return 4'd3;
            default:                     return 4'd4;
        endcase
    endfunction

    function automatic logic [AW-1:0] vec_base(input cmd_e op);
        unique case (op)
            CMD_NMI: return VEC_NMI;
            CMD_BRK: return VEC_BRK;
            default: return VEC_RST;
        endcase
    endfunction

    // Micro-operation issued in a given step of a given command.
    function automatic uop_t op_uop(input cmd_e op, input logic [CYC_W-1:0] st);
        uop_t u;
        u = '{kind: U_IDLE, sel: B_LO};
        unique case (op)
            CMD_RESET: begin
                if (st == 4'd0) u = '{kind: U_VEC, sel: B_LO};
                if (st == 4'd1) u = '{kind: U_VEC, sel: B_HI};
            end
            CMD_NMI, CMD_BRK: begin
                if (st == 4'd0) u = '{kind: U_PUSH, sel: B_HI};
                if (st == 4'd1) u = '{kind: U_PUSH, sel: B_LO};
                if (st == 4'd2) u = '{kind: U_PUSH, sel: B_ST};
                if (st == 4'd3) u = '{kind: U_VEC,  sel: B_LO};
                if (st == 4'd4) u = '{kind: U_VEC,  sel: B_HI};
            end
            CMD_RTI: begin
                if (st == 4'd0) u = '{kind: U_PULL, sel: B_ST};
                if (st == 4'd1) u = '{kind: U_PULL, sel: B_LO};
                if (st == 4'd2) u = '{kind: U_PULL, sel: B_HI};
            end
            CMD_CALL: begin
                if (st == 4'd0) u = '{kind: U_PUSH, sel: B_HI};
                if (st == 4'd1) u = '{kind: U_PUSH, sel: B_LO};
            end
            CMD_RET: begin
                if (st == 4'd0) u = '{kind: U_PULL, sel: B_LO};
                if (st == 4'd1) u = '{kind: U_PULL, sel: B_HI};
            end
            CMD_PSHA: if (st == 4'd0) u = '{kind: U_PUSH, sel: B_AC};
            CMD_PULA: if (st == 4'd0) u = '{kind: U_PULL, sel: B_AC};
            CMD_PSHS: if (st == 4'd0) u = '{kind: U_PUSH, sel: B_ST};
            default:  if (st == 4'd0) u = '{kind: U_PULL, sel: B_ST};
        endcase
        return u;
    endfunction

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
    import stk_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output cmd_e             op_q,
    output uop_t             uop,
    output logic [CYC_W-1:0] cyc_q
);
    logic [CYC_W-1:0] step_q;
    logic [CYC_W-1:0] last;

    // R13: foreign commands are only taken while idle and with a known code
    assign accept = cmd_valid && !busy && cmd_ok(cmd_op);
    assign last   = op_cost(op_q) - {{(CYC_W-1){1'b0}}, 1'b1};
    assign done   = busy && (step_q == last);
    assign uop    = busy ? op_uop(op_q, step_q) : '{kind: U_IDLE, sel: B_LO};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            step_q <= '0;
            op_q   <= CMD_RESET;
            cyc_q  <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            step_q <= '0;
            op_q   <= cmd_e'(cmd_op);
            cyc_q  <= op_cost(cmd_e'(cmd_op));
        end else if (busy) begin
            if (step_q == last) busy <= 1'b0;
            else                step_q <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/stk_seq_sp.sv
module stk_seq_sp
    import stk_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load_top,
    input  logic          push,
    input  logic          pull,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_up
);
    localparam logic [DW-1:0] SP_TOP = '1;

    assign sp_up = sp + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || load_top) sp <= SP_TOP;
        else if (push)       sp <= sp - 1'b1;
        else if (pull)       sp <= sp_up;
    end
endmodule

// File: rtl/stk_seq_dp.sv
module stk_seq_dp
    import stk_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  cmd_e          cmd_new,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] tgt_in,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] acc_in,
    input  cmd_e          op_q,
    input  uop_t          uop,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] sp_up,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] status_out,
    output logic [DW-1:0] acc_out
);
    logic [AW-1:0] ret_q;
    logic [DW-1:0] pst_q;
    logic [DW-1:0] acc_q;

    // Operands captured when a command is taken
    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q <= '0;
            pst_q <= '0;
            acc_q <= '0;
        end else if (accept) begin
            unique case (cmd_new)
                CMD_BRK:  ret_q <= pc_in + 1'b1;
                CMD_CALL: ret_q <= pc_in - 1'b1;
                default:  ret_q <= pc_in;
            endcase
            pst_q <= (cmd_new == CMD_BRK || cmd_new == CMD_PSHS)
                   ? (status_in | ST_BRKBIT | ST_ONEBIT) : status_in;
            acc_q <= acc_in;
        end
    end

    // Memory port, one access per step
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (uop.kind)
            U_PUSH: begin
                mem_wr   = 1'b1;
                mem_addr = STACK_PAGE | {{(AW-DW){1'b0}}, sp};
                unique case (uop.sel)
                    B_HI:    mem_wdata = ret_q[AW-1:DW];
                    B_LO:    mem_wdata = ret_q[DW-1:0];
                    B_ST:    mem_wdata = pst_q;
                    default: mem_wdata = acc_q;
                endcase
            end
            U_PULL: begin
                mem_rd   = 1'b1;
                mem_addr = STACK_PAGE | {{(AW-DW){1'b0}}, sp_up};
            end
            U_VEC: begin
                mem_rd   = 1'b1;
                mem_addr = vec_base(op_q) | {{(AW-1){1'b0}}, (uop.sel == B_HI)};
            end
            default: ;
        endcase
    end

    // Results
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_out     <= '0;
            status_out <= '0;
            acc_out    <= '0;
        end else begin
            if (accept) begin
                unique case (cmd_new)
                    CMD_RESET: begin
                        status_out <= '0;
                        acc_out    <= '0;
                    end
                    CMD_NMI:  status_out <= status_in | ST_MASKBIT;
                    CMD_CALL: pc_out     <= tgt_in;
                    default: ;
                endcase
            end
            if (mem_rd) begin
                unique case (uop.sel)
                    B_LO: pc_out[DW-1:0] <= mem_rdata;
                    B_HI: begin
                        if (op_q == CMD_RET) pc_out <= {mem_rdata, pc_out[DW-1:0]} + 1'b1;
                        else                 pc_out[AW-1:DW] <= mem_rdata;
                    end
                    B_ST: status_out <= (op_q == CMD_RTI)
                                      ? (mem_rdata | ST_ONEBIT)
                                      : ((mem_rdata & ~ST_BRKBIT) | ST_ONEBIT);
                    default: acc_out <= mem_rdata;
                endcase
            end
        end
    end
endmodule

// File: rtl/stk_irq_seq.sv
module stk_irq_seq
    import stk_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_op,
    input  logic [15:0] pc_in,
    input  logic [15:0] tgt_in,
    input  logic [7:0]  status_in,
    input  logic [7:0]  acc_in,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [3:0]  cycles_out,
    output logic [15:0] pc_out,
    output logic [7:0]  status_out,
    output logic [7:0]  acc_out,
    output logic [7:0]  sp_out
);
    logic          accept;
    cmd_e          op_q;
    uop_t          uop;
    logic [DW-1:0] sp_up;

    stk_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .op_q      (op_q),
        .uop       (uop),
        .cyc_q     (cycles_out)
    );

    stk_seq_sp u_sp (
        .clk      (clk),
        .rst      (rst),
        .load_top (accept && (cmd_op == CMD_RESET)),
        .push     (uop.kind == U_PUSH),
        .pull     (uop.kind == U_PULL),
        .sp       (sp_out),
        .sp_up    (sp_up)
    );

    stk_seq_dp u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cmd_new    (cmd_e'(cmd_op)),
        .pc_in      (pc_in),
        .tgt_in     (tgt_in),
        .status_in  (status_in),
        .acc_in     (acc_in),
        .op_q       (op_q),
        .uop        (uop),
        .sp         (sp_out),
        .sp_up      (sp_up),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .pc_out     (pc_out),
        .status_out (status_out),
        .acc_out    (acc_out)
    );
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        busy,
    input logic        done,
    input logic [3:0]  cycles_out,
    input logic [7:0]  sp_out
);
    logic [3:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    assert_single_access_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_length_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> ((run_cnt + 1'b1) == cycles_out));

    assert_push_addr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr == {8'h01, sp_out}));

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (sp_out == ($past(sp_out) - 8'd1)));

    assert_pull_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_addr[15:8] == 8'h01) |-> (mem_addr[7:0] == (sp_out + 8'd1)));

    assert_pull_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_addr[15:8] == 8'h01) |=> (sp_out == ($past(sp_out) + 8'd1)));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd || mem_wr));
endmodule

bind stk_irq_seq stk_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .busy       (busy),
    .done       (done),
    .cycles_out (cycles_out),
    .sp_out     (sp_out)
);

// File: tb/stk_irq_seq_bench.sv
`timescale 1ns/1ps
module stk_irq_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [15:0] pc_in = 16'h0, tgt_in = 16'h0;
    logic [7:0]  status_in = 8'h0, acc_in = 8'h0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done;
    logic [3:0]  cycles_out;
    logic [15:0] pc_out;
    logic [7:0]  status_out, acc_out, sp_out;

    always #2 clk = ~clk;

    stk_irq_seq u_stk_irq_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .pc_in(pc_in), .tgt_in(tgt_in), .status_in(status_in), .acc_in(acc_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .cycles_out(cycles_out),
        .pc_out(pc_out), .status_out(status_out), .acc_out(acc_out), .sp_out(sp_out)
    );

    // Environment memory: stack page plus the six vector bytes
    logic [7:0] stk [256];
    logic [7:0] vtab [6];
    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                       (mem_addr >= 16'hFFFA)    ? vtab[mem_addr[2:0] - 3'd2] : 8'h00;
    always @(posedge clk) if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

    int vec_cnt = 0, bad_cnt = 0;
    bit finished = 0;

    // Reference model state
    int          m_sp = 255;
    logic [15:0] m_pc = 0;
    logic [7:0]  m_st = 0, m_acc = 0;
    int          esp, nacc;
    logic        e_wr [8], e_rd [8];
    logic [15:0] e_addr [8];
    logic [7:0]  e_data [8], e_sp [8];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic m_push(input logic [7:0] b);
        e_wr[nacc] = 1; e_addr[nacc] = 16'h0100 | 16'(esp); e_data[nacc] = b;
        e_sp[nacc] = esp[7:0]; nacc++;
        esp = (esp - 1) & 255;
    endtask

    function automatic logic [7:0] m_pull();
        e_sp[nacc] = esp[7:0];
        esp = (esp + 1) & 255;
        e_rd[nacc] = 1; e_addr[nacc] = 16'h0100 | 16'(esp); e_data[nacc] = stk[esp];
        nacc++;
        return stk[esp];
    endfunction

    function automatic logic [7:0] m_vec(input logic [15:0] a);
        e_sp[nacc] = esp[7:0];
        e_rd[nacc] = 1; e_addr[nacc] = a; e_data[nacc] = vtab[a - 16'hFFFA];
        nacc++;
        return vtab[a - 16'hFFFA];
    endfunction

    task automatic do_cmd(input logic [3:0] op, input logic [15:0] pc, input logic [7:0] st,
                          input logic [7:0] ac, input logic [15:0] tg, input bit poke,
                          input string tag);
        int cost;
        logic [15:0] epc, r;
        logic [7:0]  est, eacc, lo, hi;
        nacc = 0; esp = m_sp; epc = m_pc; est = m_st; eacc = m_acc; cost = 4;
        for (int i = 0; i < 8; i++) begin
            e_wr[i] = 0; e_rd[i] = 0; e_addr[i] = 0; e_data[i] = 0;
        end
        case (op)
            4'd0: begin cost = 7; esp = 255; est = 0; eacc = 0;
                  lo = m_vec(16'hFFFC); hi = m_vec(16'hFFFD); epc = {hi, lo}; end
            4'd1: begin cost = 7; m_push(pc[15:8]); m_push(pc[7:0]); m_push(st);
                  est = st | 8'h04; lo = m_vec(16'hFFFA); hi = m_vec(16'hFFFB); epc = {hi, lo}; end
            4'd2: begin cost = 7; r = pc + 16'd1; m_push(r[15:8]); m_push(r[7:0]);
                  m_push(st | 8'h30); lo = m_vec(16'hFFFE); hi = m_vec(16'hFFFF); epc = {hi, lo}; end
            4'd3: begin cost = 6; est = m_pull() | 8'h20; lo = m_pull(); hi = m_pull(); epc = {hi, lo}; end
            4'd4: begin cost = 6; r = pc - 16'd1; m_push(r[15:8]); m_push(r[7:0]); epc = tg; end
            4'd5: begin cost = 6; lo = m_pull(); hi = m_pull(); epc = {hi, lo} + 16'd1; end
            4'd6: begin cost = 3; m_push(ac); end
            4'd7: begin cost = 4; eacc = m_pull(); end
            4'd8: begin cost = 3; m_push(st | 8'h30); end
            default: begin cost = 4; est = (m_pull() & 8'hEF) | 8'h20; end
        endcase
        for (int i = nacc; i < 8; i++) e_sp[i] = esp[7:0];

        cmd_valid = 1; cmd_op = op; pc_in = pc; status_in = st; acc_in = ac; tgt_in = tg;
        @(negedge clk);
        for (int k = 0; k < cost; k++) begin
            if (k == 0) begin cmd_valid = poke; cmd_op = 4'd6; end
            if (k == 2) cmd_valid = 0;
            chk(busy === 1'b1, tag, "busy", busy, 1);
            chk(done === (k == cost - 1), poke ? "R13" : "R12", "done", done, (k == cost - 1));
            chk(mem_wr === e_wr[k], tag, "mem_wr", mem_wr, e_wr[k]);
            chk(mem_rd === e_rd[k], tag, "mem_rd", mem_rd, e_rd[k]);
            if (e_wr[k] || e_rd[k]) chk(mem_addr === e_addr[k], tag, "mem_addr", mem_addr, e_addr[k]);
            if (e_wr[k]) chk(mem_wdata === e_data[k], tag, "mem_wdata", mem_wdata, e_data[k]);
            chk(sp_out === e_sp[k], tag, "sp_out", sp_out, e_sp[k]);
            if (k == cost - 1) begin
                chk(pc_out === epc, tag, "pc_out", pc_out, epc);
                chk(status_out === est, tag, "status_out", status_out, est);
                chk(acc_out === eacc, tag, "acc_out", acc_out, eacc);
                chk(cycles_out === 4'(cost), "R12", "cycles_out", cycles_out, cost);
            end
            @(negedge clk);
        end
        cmd_valid = 0;
        chk(busy === 1'b0 && done === 1'b0 && !mem_rd && !mem_wr, "R12", "idle after op",
            {busy, done, mem_rd, mem_wr}, 0);
        m_sp = esp; m_pc = epc; m_st = est; m_acc = eacc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad_cnt++;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        vtab[0] = 8'h78; vtab[1] = 8'h56;   // 0xFFFA/B
        vtab[2] = 8'h34; vtab[3] = 8'h12;   // 0xFFFC/D
        vtab[4] = 8'hBC; vtab[5] = 8'h9A;   // 0xFFFE/F
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(busy === 0 && done === 0 && mem_rd === 0 && mem_wr === 0, "R1", "strobes",
            {busy, done, mem_rd, mem_wr}, 0);
        chk(sp_out === 8'hFF, "R1", "sp_out", sp_out, 8'hFF);
        chk(pc_out === 0 && status_out === 0 && acc_out === 0 && cycles_out === 0, "R1", "outputs",
            {pc_out, status_out, acc_out}, 0);

        do_cmd(4'd0, 16'h0000, 8'hFF, 8'h00, 16'h0, 0, "R5");
        do_cmd(4'd6, 16'h0, 8'h00, 8'hA5, 16'h0, 0, "R10");        // push acc
        do_cmd(4'd8, 16'h0, 8'hC3, 8'h00, 16'h0, 0, "R11");        // push status, 4/5 forced
        do_cmd(4'd9, 16'h0, 8'h00, 8'h00, 16'h0, 0, "R11");        // pull status
        do_cmd(4'd7, 16'h0, 8'h00, 8'h00, 16'h0, 0, "R10");        // pull acc
        do_cmd(4'd4, 16'h2002, 8'h00, 8'h00, 16'h3000, 0, "R9");   // call
        do_cmd(4'd5, 16'h3005, 8'h00, 8'h00, 16'h0, 0, "R9");      // return
        do_cmd(4'd4, 16'h0000, 8'h00, 8'h00, 16'h4000, 0, "R9");   // call from 0: pushes FFFF
        do_cmd(4'd5, 16'h4001, 8'h00, 8'h00, 16'h0, 0, "R4");      // return wraps to 0000
        do_cmd(4'd1, 16'h4321, 8'h81, 8'h00, 16'h0, 1, "R6");      // NMI, with a held command
        do_cmd(4'd3, 16'h5678, 8'h00, 8'h00, 16'h0, 0, "R8");
        do_cmd(4'd2, 16'h1000, 8'h01, 8'h00, 16'h0, 0, "R7");      // break
        do_cmd(4'd3, 16'h9ABC, 8'h00, 8'h00, 16'h0, 0, "R8");

        // R13: undefined code leaves everything alone
        cmd_valid = 1; cmd_op = 4'd12;
        @(negedge clk);
        cmd_valid = 0;
        chk(busy === 0 && mem_rd === 0 && mem_wr === 0, "R13", "bad code strobes",
            {busy, mem_rd, mem_wr}, 0);
        chk(sp_out === 8'(m_sp), "R13", "bad code sp", sp_out, m_sp);

        // R2/R3: walk SP through both wrap points
        for (int i = 0; i < 256; i++) do_cmd(4'd6, 16'h0, 8'h00, 8'(i), 16'h0, 0, "R2");
        do_cmd(4'd7, 16'h0, 8'h00, 8'h00, 16'h0, 0, "R3");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule